// File: doc/BRIEF.md
# Block-Copy and Block-Compare Bus-Cycle Sequencer

This block executes a small slice of an 8-bit accumulator processor's instruction set, one T-state per clock, and reports every machine cycle it runs on a simple memory port. It implements the no-operation opcode, the 16-bit immediate load of the BC pair, and four prefixed string instructions. These are single-step copy, single-step compare, repeating copy and repeating compare. Each machine cycle opens with a one-clock start strobe and a two-bit kind code, so a bus model or trace recorder downstream can rebuild the exact cycle pattern of the program.

The repeating instructions do not loop internally. A pass that must continue adds a five-state internal cycle and winds the program counter back by two. The next pass therefore fetches the prefix and the opcode from memory again. The register pairs used for source and destination and the accumulator start from parameter values at reset. The BC pair is loaded by the program itself.

Top module: `blkseq_top`

## Requirements
- R1: Each machine cycle begins with `cycStart` high for exactly one clock, and `cycType` holds one value for the whole cycle: 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = internal.
- R2: A fetch lasts 4 clocks, a read 3 clocks, and a write or an internal cycle 5 clocks.
- R3: Opcode 0x00 runs as one fetch at the current PC, and the next fetch is at PC+1.
- R4: Opcode 0x01 runs as a fetch, then a read at PC+1 that loads C, then a read at PC+2 that loads B (low byte first). The next fetch is at PC+3.
- R5: Bytes 0xED,0xA0 run as fetch, fetch, read at HL, write at DE. The write stores the byte read, HL and DE each go up by one, BC goes down by one, and `flagPv` becomes 1 exactly when the new BC is non-zero.
- R6: Bytes 0xED,0xA1 run as fetch, fetch, read at HL, internal (no write). `flagZ` becomes 1 exactly when the byte read equals the accumulator, HL goes up by one, and BC and `flagPv` change as in R5.
- R7: Bytes 0xED,0xB0 run the R5 pass. When the new BC is non-zero, a 5-clock internal cycle follows and the next fetch is again at the address of the 0xED prefix. The pass that brings BC to zero ends after its write.
- R8: Bytes 0xED,0xB1 run the R6 pass. When the new BC is non-zero and the byte did not match, a second 5-clock internal cycle follows and the next fetch is again at the 0xED prefix. Otherwise the instruction ends after the first internal cycle.
- R9: While reset is high and until the first clock after it, `cycStart` is 1, `cycType` is 0 (fetch), `memAddr` is 0, `memWe` is 0 and both flags are 0.
- R10: `memWe` is high only inside a write cycle, never on its first clock, and for exactly one clock per write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Asynchronous reset, active high |
| memAddr | output | 16 | Address of the current machine cycle |
| memRdata | input | 8 | Read data, sampled on the last clock of a fetch or read |
| memWdata | output | 8 | Data for the write cycle |
| memWe | output | 1 | One-clock write strobe |
| cycType | output | 2 | Kind of the current machine cycle |
| cycStart | output | 1 | High on the first clock of each machine cycle |
| flagPv | output | 1 | Set when BC is non-zero after a block step |
| flagZ | output | 1 | Set when the last compare matched |

## Verification
On every clock the checker checks the cycle framing: a single-clock start strobe, a kind code that stays put through the cycle, the length that belongs to each kind, and exactly one write strobe that falls inside each write cycle. The choice of cycles can only be shown by the directed scenarios. These cover which cycles an opcode produces, when a repeating pass adds its extra internal cycle, where the prefix is fetched again, the order of the operand bytes, and the data copied and the flags left behind. Each scenario compares the recorded kind, length and address of every cycle against a list built from the requirements.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH    = 2'd0,
    CYC_READ     = 2'd1,
    CYC_WRITE    = 2'd2,
    CYC_INTERNAL = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ASEL_PC = 2'd0,
    ASEL_HL = 2'd1,
    ASEL_DE = 2'd2
  } addr_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      pcInc;
    logic      pcRewind;
    logic      loadC;
    logic      loadB;
    logic      loadTmp;
    logic      blkStep;
    logic      blkCopy;
    addr_sel_e addrSel;
  } dp_ctrl_t;

endpackage

// File: rtl/blkseq_ctrl.sv
module blkseq_ctrl
  import blkseq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int READ_T  = 3,
  parameter int WRITE_T = 5,
  parameter int INT_T   = 5,
  parameter int WE_T    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opByte,
  input  logic              bcWillZero,
  input  logic              accMatch,
  output dp_ctrl_t          dpCtrl,
  output cyc_kind_e         cycType,
  output logic              cycStart,
  output logic              memWe
);

  localparam int MAX_T = (WRITE_T > INT_T) ? ((WRITE_T > FETCH_T) ? WRITE_T : FETCH_T)
                                           : ((INT_T > FETCH_T) ? INT_T : FETCH_T);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [DATA_W-1:0] OP_NOP    = DATA_W'(8'h00);
  localparam logic [DATA_W-1:0] OP_LDBC   = DATA_W'(8'h01);
  localparam logic [DATA_W-1:0] OP_PREFIX = DATA_W'(8'hED);

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND_LO, ST_OPND_HI, ST_BLK_RD, ST_BLK_WR, ST_BLK_CMP, ST_BLK_REP
  } step_e;

  step_e             step;
  logic [CNT_W-1:0]  tCnt;
  logic [CNT_W-1:0]  cycLen;
  logic              lastT;
  logic              edMode;
  logic              blkLd;
  logic              blkRep;
  logic              continueRep;
  logic              isBlockOp;

  always_comb begin
    unique case (step)
      ST_FETCH:                cycLen = CNT_W'(FETCH_T);
      ST_OPND_LO, ST_OPND_HI,
      ST_BLK_RD:               cycLen = CNT_W'(READ_T);
      ST_BLK_WR:               cycLen = CNT_W'(WRITE_T);
      default:                 cycLen = CNT_W'(INT_T);
    endcase
  end

  assign lastT    = (tCnt == cycLen - CNT_W'(1));
  assign cycStart = (tCnt == '0);
  assign memWe    = (step == ST_BLK_WR) && (tCnt == CNT_W'(WE_T));

  always_comb begin
    unique case (step)
      ST_FETCH:                          cycType = CYC_FETCH;
      ST_OPND_LO, ST_OPND_HI, ST_BLK_RD: cycType = CYC_READ;
      ST_BLK_WR:                         cycType = CYC_WRITE;
      default:                           cycType = CYC_INTERNAL;
    endcase
  end

  // second byte of the four block forms: 101x000y
  assign isBlockOp   = (opByte[7:5] == 3'b101) && (opByte[3:1] == 3'b000);
  assign continueRep = blkRep && !bcWillZero && (blkLd || !accMatch);

  always_comb begin
    dpCtrl         = '0;
    dpCtrl.addrSel = ASEL_PC;
    unique case (step)
      ST_FETCH:   dpCtrl.pcInc = lastT;
      ST_OPND_LO: begin dpCtrl.pcInc = lastT; dpCtrl.loadC = lastT; end
      ST_OPND_HI: begin dpCtrl.pcInc = lastT; dpCtrl.loadB = lastT; end
      ST_BLK_RD:  begin dpCtrl.addrSel = ASEL_HL; dpCtrl.loadTmp = lastT; end
      ST_BLK_WR:  begin dpCtrl.addrSel = ASEL_DE; dpCtrl.blkStep = lastT; dpCtrl.blkCopy = 1'b1; end
      ST_BLK_CMP: begin dpCtrl.addrSel = ASEL_HL; dpCtrl.blkStep = lastT; end
      default:    dpCtrl.pcRewind = lastT;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      step   <= ST_FETCH;
      tCnt   <= '0;
      edMode <= 1'b0;
      blkLd  <= 1'b0;
      blkRep <= 1'b0;
    end else begin
      tCnt <= lastT ? '0 : tCnt + CNT_W'(1);
      if (lastT) begin
        unique case (step)
          ST_FETCH: begin
            if (edMode) begin
              edMode <= 1'b0;
              if (isBlockOp) begin
                blkLd  <= !opByte[0];
                blkRep <= opByte[4];
                step   <= ST_BLK_RD;
              end
            end else if (opByte == OP_LDBC) begin
              step <= ST_OPND_LO;
            end else if (opByte == OP_PREFIX) begin
              edMode <= 1'b1;
            end else if (opByte == OP_NOP) begin
              step <= ST_FETCH;
            end
          end
          ST_OPND_LO: step <= ST_OPND_HI;
          ST_OPND_HI: step <= ST_FETCH;
          ST_BLK_RD:  step <= blkLd ? ST_BLK_WR : ST_BLK_CMP;
          ST_BLK_WR,
          ST_BLK_CMP: step <= continueRep ? ST_BLK_REP : ST_FETCH;
          default:    step <= ST_FETCH;
        endcase
      end
    end
  end

endmodule

// File: rtl/blkseq_dpath.sv
module blkseq_dpath
  import blkseq_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [15:0]     HL_INIT  = 16'h0100,
  parameter logic [15:0]     DE_INIT  = 16'h0200,
  parameter logic [7:0]      ACC_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          dpCtrl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              bcWillZero,
  output logic              accMatch,
  output logic              flagPv,
  output logic              flagZ
);

  localparam int BC_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pc, hl, de;
  logic [BC_W-1:0]   bc, bcNext;
  logic [DATA_W-1:0] acc, tmp;

  assign bcNext     = bc - BC_W'(1);
  assign bcWillZero = (bcNext == '0);
  assign accMatch   = (acc == tmp);
  assign memWdata   = tmp;

  always_comb begin
    unique case (dpCtrl.addrSel)
      ASEL_HL: memAddr = hl;
      ASEL_DE: memAddr = de;
      default: memAddr = pc;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pc     <= '0;
      bc     <= '0;
      hl     <= ADDR_W'(HL_INIT);
      de     <= ADDR_W'(DE_INIT);
      acc    <= DATA_W'(ACC_INIT);
      tmp    <= '0;
      flagPv <= 1'b0;
      flagZ  <= 1'b0;
    end else begin
      if (dpCtrl.pcInc)    pc <= pc + ADDR_W'(1);
      if (dpCtrl.pcRewind) pc <= pc - ADDR_W'(2);
      if (dpCtrl.loadC)    bc[DATA_W-1:0]    <= memRdata;
      if (dpCtrl.loadB)    bc[BC_W-1:DATA_W] <= memRdata;
      if (dpCtrl.loadTmp)  tmp <= memRdata;
      if (dpCtrl.blkStep) begin
        hl     <= hl + ADDR_W'(1);
        bc     <= bcNext;
        flagPv <= !bcWillZero;
        if (dpCtrl.blkCopy) de    <= de + ADDR_W'(1);
        else                flagZ <= accMatch;
      end
    end
  end

endmodule

// File: rtl/blkseq_top.sv
module blkseq_top
  import blkseq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] HL_INIT  = 16'h0100,
  parameter logic [15:0] DE_INIT  = 16'h0200,
  parameter logic [7:0]  ACC_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic [1:0]        cycType,
  output logic              cycStart,
  output logic              flagPv,
  output logic              flagZ
);

  dp_ctrl_t  dpCtrl;
  cyc_kind_e cycKind;
  logic      bcWillZero;
  logic      accMatch;

  blkseq_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst(rst), .opByte(memRdata),
    .bcWillZero(bcWillZero), .accMatch(accMatch),
    .dpCtrl(dpCtrl), .cycType(cycKind), .cycStart(cycStart), .memWe(memWe)
  );

  blkseq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .HL_INIT(HL_INIT), .DE_INIT(DE_INIT), .ACC_INIT(ACC_INIT)
  ) i_dpath (
    .clk(clk), .rst(rst), .dpCtrl(dpCtrl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .bcWillZero(bcWillZero), .accMatch(accMatch),
    .flagPv(flagPv), .flagZ(flagZ)
  );

  assign cycType = cycKind;

endmodule

// File: rtl/blkseq_checker.sv
module blkseq_checker #(
  parameter int FETCH_T = 4,
  parameter int READ_T  = 3,
  parameter int WRITE_T = 5,
  parameter int INT_T   = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       cycStart,
  input logic [1:0] cycType,
  input logic       memWe
);

  logic [7:0] runLen;
  logic [1:0] runType;
  logic [3:0] weCnt;
  logic       seen;

  function automatic logic [7:0] lenOf(input logic [1:0] kind);
    case (kind)
      2'd0:    return 8'(FETCH_T);
      2'd1:    return 8'(READ_T);
      2'd2:    return 8'(WRITE_T);
      default: return 8'(INT_T);
    endcase
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      runLen  <= '0;
      runType <= 2'd0;
      weCnt   <= '0;
      seen    <= 1'b0;
    end else if (cycStart) begin
      runLen  <= 8'd1;
      runType <= cycType;
      weCnt   <= memWe ? 4'd1 : 4'd0;
      seen    <= 1'b1;
    end else begin
      runLen <= runLen + 8'd1;
      if (memWe) weCnt <= weCnt + 4'd1;
    end
  end

  a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
    cycStart |=> !cycStart);

  a_r1_type_hold: assert property (@(posedge clk) disable iff (rst)
    (!cycStart && seen) |-> (cycType == runType));

  a_r2_cycle_len: assert property (@(posedge clk) disable iff (rst)
    (cycStart && seen) |-> (runLen == lenOf(runType)));

  a_r10_we_in_write: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (cycType == 2'd2 && !cycStart));

  a_r10_we_single: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe);

  a_r10_we_per_cycle: assert property (@(posedge clk) disable iff (rst)
    (cycStart && seen && runType == 2'd2) |-> (weCnt == 4'd1));

endmodule

bind blkseq_top blkseq_checker i_checker (
  .clk(clk), .rst(rst), .cycStart(cycStart), .cycType(cycType), .memWe(memWe)
);

// File: tb/test_blkseq_top.sv
`timescale 1ns/100ps
module test_blkseq_top;

  localparam logic [7:0] ACC_VAL = 8'h5A;
  localparam int F = 0, RD = 1, WR = 2, IN = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic [7:0]  memRdata;
  logic [7:0]  memWdata;
  logic        memWe;
  logic [1:0]  cycType;
  logic        cycStart;
  logic        flagPv;
  logic        flagZ;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [0:4095];

  int logType [0:63];
  int logLen  [0:63];
  int logAddr [0:63];
  int logN = 0;
  int curType = 0, curLen = 0, curAddr = 0;
  int wrCount = 0;

  int expType [0:63];
  int expLen  [0:63];
  int expAddr [0:63];
  int expN = 0;

  always #2.5 clk = ~clk;

  blkseq_top #(.ACC_INIT(ACC_VAL)) i_blkseq_top (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memWe(memWe), .cycType(cycType),
    .cycStart(cycStart), .flagPv(flagPv), .flagZ(flagZ)
  );

  assign memRdata = mem[memAddr[11:0]];

  always @(posedge clk) if (!rst && memWe) mem[memAddr[11:0]] <= memWdata;

  // cycle recorder
  always @(negedge clk) begin
    if (!rst) begin
      if (memWe) wrCount++;
      if (cycStart) begin
        if (curLen > 0 && logN < 64) begin
          logType[logN] = curType;
          logLen[logN]  = curLen;
          logAddr[logN] = curAddr;
          logN++;
        end
        curType = int'(cycType);
        curAddr = int'(memAddr);
        curLen  = 1;
      end else begin
        curLen++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic startRun();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    logN = 0; curLen = 0; wrCount = 0; expN = 0;
    #1 rst = 1'b0;
  endtask

  task automatic addExp(input int t, input int l, input int a);
    expType[expN] = t; expLen[expN] = l; expAddr[expN] = a;
    expN++;
  endtask

  task automatic addFetch(input int a); addExp(F, 4, a); endtask

  task automatic checkSeq(input string req);
    int waited = 0;
    while (logN < expN && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (logN < expN) begin
      check(req, logN, expN, "cycle count (timeout)");
      return;
    end
    for (int i = 0; i < expN; i++) begin
      check(req, logType[i], expType[i], $sformatf("type of cycle %0d", i));
      check(req, logLen[i], expLen[i], $sformatf("length of cycle %0d", i));
      if (expAddr[i] >= 0)
        check(req, logAddr[i], expAddr[i], $sformatf("address of cycle %0d", i));
    end
  endtask

  // R9: reset values
  task automatic testReset();
    clearMem();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", int'(cycStart), 1, "cycStart in reset");
    check("R9", int'(cycType), F, "cycType in reset");
    check("R9", int'(memAddr), 0, "memAddr in reset");
    check("R9", int'(memWe), 0, "memWe in reset");
    check("R9", int'({flagPv, flagZ}), 0, "flags in reset");
  endtask

  // R3: plain NOPs
  task automatic testNop();
    clearMem();
    startRun();
    addFetch(0); addFetch(1); addFetch(2);
    checkSeq("R3");
  endtask

  // R4 + R7: LD BC,0x0003 then repeating copy of three bytes
  task automatic testLdbcCopyRepeat();
    clearMem();
    mem[0] = 8'h01; mem[1] = 8'h03; mem[2] = 8'h00;
    mem[3] = 8'hED; mem[4] = 8'hB0;
    mem[12'h100] = 8'h11; mem[12'h101] = 8'h22; mem[12'h102] = 8'h33;
    startRun();
    addFetch(0); addExp(RD, 3, 1); addExp(RD, 3, 2);
    for (int p = 0; p < 3; p++) begin
      addFetch(3); addFetch(4);
      addExp(RD, 3, 16'h100 + p);
      addExp(WR, 5, 16'h200 + p);
      if (p < 2) addExp(IN, 5, -1);
    end
    addFetch(5);
    checkSeq("R7");
    check("R4", logN >= 8 ? logType[7] : -1, IN, "low operand byte sets pass count (R7 repeat)");
    check("R7", int'(mem[12'h200]), 8'h11, "copied byte 0");
    check("R7", int'(mem[12'h201]), 8'h22, "copied byte 1");
    check("R7", int'(mem[12'h202]), 8'h33, "copied byte 2");
    check("R7", wrCount, 3, "write strobes");
    check("R7", int'(flagPv), 0, "flagPv after last pass");
  endtask

  // R5: single copy, BC 0 -> FFFF
  task automatic testCopyOnce();
    clearMem();
    mem[0] = 8'hED; mem[1] = 8'hA0;
    mem[12'h100] = 8'h77; mem[12'h101] = 8'h99;
    startRun();
    addFetch(0); addFetch(1); addExp(RD, 3, 16'h100); addExp(WR, 5, 16'h200); addFetch(2);
    checkSeq("R5");
    check("R5", int'(mem[12'h200]), 8'h77, "copied byte");
    check("R5", int'(mem[12'h201]), 8'h00, "neighbour untouched");
    check("R5", wrCount, 1, "write strobes");
    check("R5", int'(flagPv), 1, "flagPv with BC non-zero");
  endtask

  // R6: single compare, match
  task automatic testCompareOnce();
    clearMem();
    mem[0] = 8'hED; mem[1] = 8'hA1;
    mem[12'h100] = ACC_VAL;
    startRun();
    addFetch(0); addFetch(1); addExp(RD, 3, 16'h100); addExp(IN, 5, -1); addFetch(2);
    checkSeq("R6");
    check("R6", wrCount, 0, "no write strobe");
    check("R6", int'(flagZ), 1, "flagZ on match");
    check("R6", int'(flagPv), 1, "flagPv with BC non-zero");
  endtask

  // R8: repeating compare, BC=2, no match
  task automatic testCompareRepeat();
    clearMem();
    mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h00;
    mem[3] = 8'hED; mem[4] = 8'hB1;
    mem[12'h100] = 8'h01; mem[12'h101] = 8'h02;
    startRun();
    addFetch(0); addExp(RD, 3, 1); addExp(RD, 3, 2);
    addFetch(3); addFetch(4); addExp(RD, 3, 16'h100); addExp(IN, 5, -1); addExp(IN, 5, -1);
    addFetch(3); addFetch(4); addExp(RD, 3, 16'h101); addExp(IN, 5, -1);
    addFetch(5); addFetch(6);
    checkSeq("R8");
    check("R8", wrCount, 0, "no write strobe");
    check("R8", int'(flagZ), 0, "flagZ without match");
    check("R8", int'(flagPv), 0, "flagPv at BC zero");
  endtask

  // R8: repeating compare stops early on a match
  task automatic testCompareMatchStop();
    clearMem();
    mem[0] = 8'h01; mem[1] = 8'h05; mem[2] = 8'h00;
    mem[3] = 8'hED; mem[4] = 8'hB1;
    mem[12'h100] = 8'h01; mem[12'h101] = ACC_VAL; mem[12'h102] = 8'h03;
    startRun();
    addFetch(0); addExp(RD, 3, 1); addExp(RD, 3, 2);
    addFetch(3); addFetch(4); addExp(RD, 3, 16'h100); addExp(IN, 5, -1); addExp(IN, 5, -1);
    addFetch(3); addFetch(4); addExp(RD, 3, 16'h101); addExp(IN, 5, -1);
    addFetch(5);
    checkSeq("R8");
    check("R8", int'(flagZ), 1, "flagZ after match stop");
    check("R8", int'(flagPv), 1, "flagPv with BC still non-zero");
  endtask

  initial begin
    fork
      begin
        testReset();
        testNop();
        testLdbcCopyRepeat();
        testCopyOnce();
        testCompareOnce();
        testCompareRepeat();
        testCompareMatchStop();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule